// File: doc/BRIEF.md
# Access Fault Detector

This block watches the load/store stage of a processor pipeline. Each cycle it may see one memory access, made up of an effective address, a size mask, a direction flag and the index of the register the access targets. The size mask is 0 for a byte, 1 for a halfword and 3 for a word. If the address has any bit set under the mask, the block records the address and builds a status word that describes the fault. The status word is updated even when exceptions are switched off. A one-cycle exception request is raised only when exceptions are switched on.

A second source of faults is a bus error reported by the fabric, either on an instruction fetch or on a data access. For a bus error, the fault address is captured only when exceptions are enabled. A cause is recorded and a request is raised only if the configuration bit for that kind of bus also allows it. When a misaligned access and a bus error arrive in the same cycle, the misalignment wins and the bus error is dropped. All outputs are registered and change on the clock edge that follows the event.

Top module: `access_fault_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `fault_addr` and `fault_status` are zero and `exc_req` is low.
- R2: When `acc_valid` is high and `acc_addr & acc_size_mask` is non-zero, `fault_addr` holds `acc_addr` after the next rising edge.
- R3: On a misaligned access, `fault_status` is written as follows. Bits 4:0 hold cause code 1. Bits 9:5 hold `acc_reg_idx`. Bit 10 holds `acc_write`. Every bit above bit 11 is zero.
- R4: On a misaligned access, bit 11 of `fault_status` is 1 when `acc_size_mask` is 3 (word) and 0 when it is 1 (halfword).
- R5: A valid access with `acc_addr & acc_size_mask` equal to zero leaves both registers unchanged and raises no request. This includes any address with mask 0.
- R6: On a misaligned access, `fault_addr` and `fault_status` are written whatever the value of `exc_enable`. `exc_req` is high in the following cycle only if `exc_enable` was high.
- R7: A bus error with `exc_enable` high always loads `bus_err_addr` into `fault_addr`. If the matching configuration bit is set, the status becomes cause 3 for a fetch (gated by `cfg_ibus_exc_en`) or cause 4 for a data access (gated by `cfg_dbus_exc_en`), and `exc_req` pulses. If that bit is clear, the status is unchanged and there is no request.
- R8: A bus error while `exc_enable` is low changes neither register and raises no request.
- R9: When a misaligned access and a bus error occur in the same cycle, only the misalignment is recorded.
- R10: `exc_req` is high for exactly one cycle per accepted event. In a cycle with no access and no bus error, the registers hold and `exc_req` is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Effective address of the access |
| acc_size_mask | input | MASK_W | Alignment mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_reg_idx | input | 5 | Register index targeted by the access |
| exc_enable | input | 1 | Global exception enable |
| bus_err_valid | input | 1 | Bus error reported this cycle |
| bus_err_addr | input | ADDR_W | Address that caused the bus error |
| bus_err_fetch | input | 1 | 1 if the bus error came from an instruction fetch |
| cfg_ibus_exc_en | input | 1 | Allow exceptions for instruction-bus errors |
| cfg_dbus_exc_en | input | 1 | Allow exceptions for data-bus errors |
| fault_addr | output | ADDR_W | Captured fault address |
| fault_status | output | STATUS_W | Fault status word |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 2-bit size mask and a 32-bit status word. With a 32-bit status word, the bench can check that the bits above the word-size flag stay zero. With the 2-bit mask, every size can be tested: byte, halfword and word, each at aligned and misaligned offsets. The sequences cover both exception-enable states and both configuration bits. They include a bus error arriving in the same cycle as a misalignment, and misaligned accesses in consecutive cycles, to test the single-cycle request.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int REG_IDX_W  = 5;
  localparam int CAUSE_W    = 5;
  localparam int IDX_LSB    = 5;
  localparam int WR_BIT     = 10;
  localparam int WORD_BIT   = 11;
  localparam int STATUS_MIN = WORD_BIT + 1;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_IBUS     = 5'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_DBUS     = 5'd4;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MISALIGN,
    SRC_BUS_ADDR,
    SRC_BUS_FULL
  } fault_src_e;
endpackage

// File: rtl/afd_misalign.sv
module afd_misalign
  import afd_pkg::*;
#(
  parameter int MASK_W   = 2,
  parameter int STATUS_W = 32
) (
  input  logic                 valid,
  input  logic [MASK_W-1:0]    addr_lo,
  input  logic [MASK_W-1:0]    size_mask,
  input  logic                 is_write,
  input  logic [REG_IDX_W-1:0] reg_idx,
  output logic                 hit,
  output logic [STATUS_W-1:0]  status_word
);
  logic [MASK_W-1:0] overlap;
  logic              word_sized;

  for (genvar g = 0; g < MASK_W; g++) begin : g_overlap
    assign overlap[g] = addr_lo[g] & size_mask[g];
  end

  assign hit        = valid & (|overlap);
  assign word_sized = &size_mask;

  always_comb begin
    status_word                               = '0;
    status_word[CAUSE_W-1:0]                  = CAUSE_MISALIGN;
    status_word[IDX_LSB+REG_IDX_W-1:IDX_LSB]  = reg_idx;
    status_word[WR_BIT]                       = is_write;
    status_word[WORD_BIT]                     = word_sized;
  end
endmodule

// File: rtl/afd_buserr.sv
module afd_buserr
  import afd_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                err_valid,
  input  logic                is_fetch,
  input  logic                exc_en,
  input  logic                ibus_en,
  input  logic                dbus_en,
  output logic                load_addr,
  output logic                load_cause,
  output logic [STATUS_W-1:0] cause_word
);
  logic kind_allowed;

  assign kind_allowed = is_fetch ? ibus_en : dbus_en;
  assign load_addr    = err_valid & exc_en;
  assign load_cause   = load_addr & kind_allowed;

  always_comb begin
    cause_word              = '0;
    cause_word[CAUSE_W-1:0] = is_fetch ? CAUSE_IBUS : CAUSE_DBUS;
  end
endmodule

// File: rtl/afd_regs.sv
module afd_regs
  import afd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mis_hit,
  input  logic [ADDR_W-1:0]   mis_addr,
  input  logic [STATUS_W-1:0] mis_status,
  input  logic                exc_en,
  input  logic                bus_load_addr,
  input  logic                bus_load_cause,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [STATUS_W-1:0] bus_status,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [STATUS_W-1:0] status_q,
  output logic                req_q
);
  fault_src_e sel;

  always_comb begin
    if (mis_hit)             sel = SRC_MISALIGN;
    else if (bus_load_cause) sel = SRC_BUS_FULL;
    else if (bus_load_addr)  sel = SRC_BUS_ADDR;
    else                     sel = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      status_q <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (sel)
        SRC_MISALIGN: begin
          addr_q   <= mis_addr;
          status_q <= mis_status;
          req_q    <= exc_en;
        end
        SRC_BUS_FULL: begin
          addr_q   <= bus_addr;
          status_q <= bus_status;
          req_q    <= 1'b1;
        end
        SRC_BUS_ADDR: begin
          addr_q   <= bus_addr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/access_fault_detect.sv
module access_fault_detect
  import afd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MASK_W   = 2,
  parameter int STATUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [MASK_W-1:0]    acc_size_mask,
  input  logic                 acc_write,
  input  logic [REG_IDX_W-1:0] acc_reg_idx,
  input  logic                 exc_enable,
  input  logic                 bus_err_valid,
  input  logic [ADDR_W-1:0]    bus_err_addr,
  input  logic                 bus_err_fetch,
  input  logic                 cfg_ibus_exc_en,
  input  logic                 cfg_dbus_exc_en,
  output logic [ADDR_W-1:0]    fault_addr,
  output logic [STATUS_W-1:0]  fault_status,
  output logic                 exc_req
);
  logic                mis_hit;
  logic [STATUS_W-1:0] mis_status;
  logic                bus_load_addr;
  logic                bus_load_cause;
  logic [STATUS_W-1:0] bus_status;

  afd_misalign #(.MASK_W(MASK_W), .STATUS_W(STATUS_W)) u_mis (
    .valid       (acc_valid),
    .addr_lo     (acc_addr[MASK_W-1:0]),
    .size_mask   (acc_size_mask),
    .is_write    (acc_write),
    .reg_idx     (acc_reg_idx),
    .hit         (mis_hit),
    .status_word (mis_status)
  );

  afd_buserr #(.STATUS_W(STATUS_W)) u_bus (
    .err_valid  (bus_err_valid),
    .is_fetch   (bus_err_fetch),
    .exc_en     (exc_enable),
    .ibus_en    (cfg_ibus_exc_en),
    .dbus_en    (cfg_dbus_exc_en),
    .load_addr  (bus_load_addr),
    .load_cause (bus_load_cause),
    .cause_word (bus_status)
  );

  afd_regs #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .mis_hit        (mis_hit),
    .mis_addr       (acc_addr),
    .mis_status     (mis_status),
    .exc_en         (exc_enable),
    .bus_load_addr  (bus_load_addr),
    .bus_load_cause (bus_load_cause),
    .bus_addr       (bus_err_addr),
    .bus_status     (bus_status),
    .addr_q         (fault_addr),
    .status_q       (fault_status),
    .req_q          (exc_req)
  );
endmodule

// File: rtl/access_fault_detect_chk.sv
module access_fault_detect_chk #(
  parameter int ADDR_W   = 32,
  parameter int MASK_W   = 2,
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic [MASK_W-1:0]   acc_size_mask,
  input logic                exc_enable,
  input logic                bus_err_valid,
  input logic [ADDR_W-1:0]   fault_addr,
  input logic [STATUS_W-1:0] fault_status,
  input logic                exc_req
);
  logic misaligned;
  assign misaligned = acc_valid && ((acc_addr[MASK_W-1:0] & acc_size_mask) != '0);

  AST_MISALIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
    misaligned |=> fault_addr == $past(acc_addr)); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    fault_status[STATUS_W-1:12] == '0); // R3
  AST_WORD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (misaligned && (&acc_size_mask)) |=> fault_status[11]); // R4
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(exc_enable)); // R6
  AST_BUS_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && bus_err_valid && !exc_enable) |=>
      ($stable(fault_addr) && $stable(fault_status) && !exc_req)); // R8
  AST_MISALIGN_WINS: assert property (@(posedge clk) disable iff (rst)
    (misaligned && bus_err_valid) |=> fault_status[4:0] == 5'd1); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !bus_err_valid) |=>
      ($stable(fault_addr) && $stable(fault_status) && !exc_req)); // R10
endmodule

bind access_fault_detect access_fault_detect_chk #(
  .ADDR_W(ADDR_W), .MASK_W(MASK_W), .STATUS_W(STATUS_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_valid     (acc_valid),
  .acc_addr      (acc_addr),
  .acc_size_mask (acc_size_mask),
  .exc_enable    (exc_enable),
  .bus_err_valid (bus_err_valid),
  .fault_addr    (fault_addr),
  .fault_status  (fault_status),
  .exc_req       (exc_req)
);

// File: tb/access_fault_detect_tb.sv
module access_fault_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 32;
  localparam int MASK_W   = 2;
  localparam int STATUS_W = 32;

  typedef struct {
    logic [ADDR_W-1:0]   addr;
    logic [STATUS_W-1:0] status;
    logic                req;
    string               tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [MASK_W-1:0] acc_size_mask = '0;
  logic acc_write = 1'b0;
  logic [4:0] acc_reg_idx = '0;
  logic exc_enable = 1'b0;
  logic bus_err_valid = 1'b0;
  logic [ADDR_W-1:0] bus_err_addr = '0;
  logic bus_err_fetch = 1'b0;
  logic cfg_ibus_exc_en = 1'b0;
  logic cfg_dbus_exc_en = 1'b0;
  logic [ADDR_W-1:0] fault_addr;
  logic [STATUS_W-1:0] fault_status;
  logic exc_req;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [ADDR_W-1:0]   m_addr = '0;
  logic [STATUS_W-1:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_fault_detect #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .STATUS_W(STATUS_W)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size_mask(acc_size_mask), .acc_write(acc_write), .acc_reg_idx(acc_reg_idx),
    .exc_enable(exc_enable), .bus_err_valid(bus_err_valid), .bus_err_addr(bus_err_addr),
    .bus_err_fetch(bus_err_fetch), .cfg_ibus_exc_en(cfg_ibus_exc_en),
    .cfg_dbus_exc_en(cfg_dbus_exc_en), .fault_addr(fault_addr),
    .fault_status(fault_status), .exc_req(exc_req)
  );

  // Driver: sets inputs at the falling edge and queues the expected result.
  task automatic drive(input logic v, input logic [ADDR_W-1:0] a, input logic [1:0] m,
                       input logic wr, input logic [4:0] rd, input logic ee,
                       input logic bv, input logic [ADDR_W-1:0] ba, input logic bf,
                       input logic ien, input logic den, input string tag);
    exp_t e;
    logic mis;
    logic req;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size_mask = m; acc_write = wr; acc_reg_idx = rd;
    exc_enable = ee; bus_err_valid = bv; bus_err_addr = ba; bus_err_fetch = bf;
    cfg_ibus_exc_en = ien; cfg_dbus_exc_en = den;
    mis = v && ((a[1:0] & m) != 2'b00);
    req = 1'b0;
    if (mis) begin
      m_addr = a;
      m_stat = 32'd1 | (32'(rd) << 5) | (32'(wr) << 10) | ((m == 2'd3) ? 32'h800 : 32'h0);
      req = ee;
    end else if (bv && ee) begin
      m_addr = ba;
      if (bf ? ien : den) begin
        m_stat = bf ? 32'd3 : 32'd4;
        req = 1'b1;
      end
    end
    e.addr = m_addr; e.status = m_stat; e.req = req; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares one queued item just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (fault_addr !== e.addr || fault_status !== e.status || exc_req !== e.req) begin
          fails++;
          $display("FAIL %s: got addr=%h status=%h req=%b, expected addr=%h status=%h req=%b",
                   e.tag, fault_addr, fault_status, exc_req, e.addr, e.status, e.req);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (fault_addr !== '0 || fault_status !== '0 || exc_req !== 1'b0) begin
      fails++;
      $display("FAIL R1: got addr=%h status=%h req=%b, expected all zero",
               fault_addr, fault_status, exc_req);
    end
    @(negedge clk);
    rst = 1'b0;
    idle("R1 after reset");
    // R2 R3 R4 halfword misaligned, enabled
    drive(1'b1, 32'h0000_1001, 2'd1, 1'b0, 5'd7, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 R3 halfword");
    // R4 R6 word misaligned store, exceptions disabled: registers still written
    drive(1'b1, 32'h0000_2002, 2'd3, 1'b1, 5'd31, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R4 R6 word disabled");
    // R5 aligned word, byte at odd address, aligned halfword
    drive(1'b1, 32'h0000_3000, 2'd3, 1'b1, 5'd2, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5 aligned word");
    drive(1'b1, 32'h0000_3003, 2'd0, 1'b0, 5'd3, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5 byte");
    drive(1'b1, 32'h0000_3006, 2'd1, 1'b0, 5'd4, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5 aligned half");
    // R5 misaligned address with valid low is ignored
    drive(1'b0, 32'h0000_3007, 2'd3, 1'b0, 5'd4, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5 not valid");
    idle("R10 idle");
    // R7 fetch bus error, enabled
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b1, 1'b1, 32'hDEAD_BEE0, 1'b1, 1'b1, 1'b0, "R7 ibus");
    // R7 data bus error with its config bit clear: address only
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b1, 1'b1, 32'hCAFE_0010, 1'b0, 1'b1, 1'b0, "R7 dbus gated");
    // R7 fetch gated by its own bit while data bit set
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b1, 1'b1, 32'hCAFE_0020, 1'b1, 1'b0, 1'b1, "R7 ibus gated");
    // R8 bus error with exceptions off
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b1, 1'b1, "R8 disabled");
    // R7 data bus error allowed
    drive(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b1, 1'b1, 32'h0BAD_0000, 1'b0, 1'b0, 1'b1, "R7 dbus");
    // R9 simultaneous events
    drive(1'b1, 32'h0000_4001, 2'd1, 1'b1, 5'd12, 1'b1, 1'b1, 32'h9999_0000, 1'b0, 1'b1, 1'b1, "R9 priority");
    // R10 back-to-back misaligned then idle
    drive(1'b1, 32'h0000_5003, 2'd3, 1'b0, 5'd1, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 first");
    drive(1'b1, 32'h0000_6001, 2'd3, 1'b1, 5'd30, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 second");
    idle("R10 drop");
    // R2 R4 sweep of low address bits for both sizes
    for (int off = 0; off < 4; off++) begin
      drive(1'b1, 32'hA000_0000 + 32'(off), 2'd3, off[0], 5'(off + 16), 1'b1,
            1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 R4 word sweep");
      drive(1'b1, 32'hB000_0000 + 32'(off), 2'd1, off[1], 5'(off + 8), off[0],
            1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 R4 R6 half sweep");
    end
    idle("R10 end");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule